// File: doc/BRIEF.md
# Open-Row DRAM Controller

This block lets a synchronous host use an asynchronous DRAM device. A host request carries an address, a write flag and write data. The upper address bits select a row and the lower bits select a column. The controller drives the device's shared address pins, its four active-low strobes and a split data bus: an output, an output enable and an input. Every device timing limit is a cycle count held in a parameter, rounded up from the device's nanosecond figures at the chosen clock.

After an access the row stays open. A later request to the same row gets a column strobe only. A request to another row first closes the open row, then opens the new row, then does the column access. An internal timer asks for a refresh at a fixed interval. The refresh strobes the column line before the row line. It runs between host requests, takes priority over them, and leaves every row closed.

Top module: `dram_ctrl`

## Requirements
- R1: The row address, taken from the upper ROW_W bits of the request address, is on `dram_addr_o` for at least one cycle before `ras_n_o` falls. It is unchanged on the falling edge.
- R2: The column address, taken from the lower COL_W bits of the request address, is on `dram_addr_o` for at least one cycle before `cas_n_o` falls. It is unchanged on the falling edge.
- R3: On the CAS fall of a write, `we_n_o` is 0, `oe_n_o` is 1, `dq_oe_o` is 1 and `dq_o` carries the request data. A later read of that address returns this data.
- R4: On the CAS fall of a read, `we_n_o` is 1 and `oe_n_o` is 0. Whenever `oe_n_o` is low, `dq_oe_o` is 0 in that cycle and was also 0 in the cycle before.
- R5: A read returns one `rsp_valid_o` pulse, in request order. The data in `rsp_data_o` is sampled no earlier than T_RAC cycles after the last RAS fall and no earlier than T_CAC cycles after the CAS fall.
- R6: Two RAS falling edges are at least T_RC cycles apart.
- R7: Two CAS falling edges are at least T_PC cycles apart.
- R8: A request to the row that is still open gets no RAS activity before its column strobe.
- R9: A request to a closed row, or to a different row, gets a RAS rise when a row was open, then a new row activation, before its column strobe.
- R10: A refresh starts at least once every T_REF cycles, apart from the time spent finishing the access in progress. In a refresh `cas_n_o` is low before `ras_n_o` falls. After a refresh no row is open.
- R11: A pending refresh takes priority over host requests. `req_ready_o` stays low and the refresh runs before the next request is accepted, so no accepted request is waiting when it starts.
- R12: While reset is active and right after it, all four strobes are high, `dq_oe_o` is 0, `rsp_valid_o` is 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | ROW_W+COL_W | Request address: the row in the upper bits, the column in the lower bits |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| rsp_data_o | output | DATA_W | Read data |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed device address |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| dq_o | output | DATA_W | Data driven toward the device |
| dq_oe_o | output | 1 | Drive enable for dq_o |
| dq_i | input | DATA_W | Data returned by the device |

## Verification
The bench uses 4 row bits, 4 column bits and 8 data bits, so a 256-word device model covers the whole address space. Short strides produce same-row hits, different-row misses and back-to-back hit streams. The timing counts stay at their defaults (6, 2, 11, 4). The refresh interval is cut to 150 cycles, so a refresh lands dozens of times among hits, misses and idle gaps, including in the middle of a continuous request stream. Before T_RAC or T_CAC has elapsed the device model returns inverted data, so any early sample shows up as a data mismatch.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_ACT,
    ST_COL,
    ST_PRE,
    ST_REF
  } state_e;
endpackage

// File: rtl/dram_age_cnt.sv
// Saturating count of cycles since the last restart; resets saturated.
module dram_age_cnt #(
  parameter int unsigned MAX = 11,
  parameter int unsigned W   = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  output logic [W-1:0] age_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                age_o <= W'(MAX);
    else if (restart_i)         age_o <= W'(1);
    else if (age_o != W'(MAX))  age_o <= age_o + W'(1);
  end
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned T_REF = 1560,
  localparam int unsigned W    = $clog2(T_REF)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  logic [W-1:0] cnt_q;
  logic         tick;

  assign tick = (cnt_q == W'(T_REF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + W'(1);
      if (tick)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned T_RAC  = 6,
  parameter int unsigned T_CAC  = 2,
  parameter int unsigned T_RC   = 11,
  parameter int unsigned T_PC   = 4,
  parameter int unsigned T_REF  = 1560,
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [PIN_W-1:0]  dram_addr_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int unsigned MAX_A   = (T_RC > T_RAC) ? T_RC : T_RAC;
  localparam int unsigned MAX_B   = (T_PC > T_CAC) ? T_PC : T_CAC;
  localparam int unsigned AGE_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned AW      = $clog2(AGE_MAX + 1);

  state_e            state_q;
  logic [1:0]        step_q;
  logic [ROW_W-1:0]  lat_row_q, open_row_q;
  logic [COL_W-1:0]  lat_col_q;
  logic              lat_we_q, open_q, pre_ref_q;
  logic [DATA_W-1:0] lat_wdata_q;
  logic [AW-1:0]     ras_age, cas_age;
  logic              drop_ras, drop_cas, ref_pend, ref_ack;
  logic              rc_ok, pc_ok, data_ok, accept, hit;

  dram_age_cnt #(.MAX(AGE_MAX), .W(AW)) i_ras_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(drop_ras), .age_o(ras_age));
  dram_age_cnt #(.MAX(AGE_MAX), .W(AW)) i_cas_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(drop_cas), .age_o(cas_age));
  dram_ref_timer #(.T_REF(T_REF)) i_ref_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ref_ack), .pend_o(ref_pend));

  assign rc_ok       = ras_age >= AW'(T_RC);
  assign pc_ok       = cas_age >= AW'(T_PC);
  assign data_ok     = (ras_age >= AW'(T_RAC)) && (cas_age >= AW'(T_CAC));
  assign req_ready_o = (state_q == ST_IDLE) && !ref_pend;
  assign accept      = req_valid_i && req_ready_o;
  assign hit         = open_q && (req_addr_i[ADDR_W-1 -: ROW_W] == open_row_q);
  assign ref_ack     = (state_q == ST_REF) && drop_ras;

  always_comb begin
    drop_ras = 1'b0;
    drop_cas = 1'b0;
    unique case (state_q)
      ST_ROW_ACT: drop_ras = rc_ok;
      ST_COL:     drop_cas = (step_q == 2'd1) && pc_ok;
      ST_REF: begin
        drop_cas = (step_q == 2'd0) && pc_ok;   // CAS before RAS
        drop_ras = (step_q == 2'd1) && rc_ok;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      step_q      <= '0;
      ras_n_o     <= 1'b1;
      cas_n_o     <= 1'b1;
      we_n_o      <= 1'b1;
      oe_n_o      <= 1'b1;
      dq_oe_o     <= 1'b0;
      dq_o        <= '0;
      dram_addr_o <= '0;
      open_q      <= 1'b0;
      open_row_q  <= '0;
      pre_ref_q   <= 1'b0;
      lat_row_q   <= '0;
      lat_col_q   <= '0;
      lat_we_q    <= 1'b0;
      lat_wdata_q <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ref_pend) begin
            step_q <= '0;
            if (open_q) begin
              ras_n_o   <= 1'b1;
              open_q    <= 1'b0;
              pre_ref_q <= 1'b1;
              state_q   <= ST_PRE;
            end else begin
              state_q <= ST_REF;
            end
          end else if (accept) begin
            lat_row_q   <= req_addr_i[ADDR_W-1 -: ROW_W];
            lat_col_q   <= req_addr_i[COL_W-1:0];
            lat_we_q    <= req_we_i;
            lat_wdata_q <= req_wdata_i;
            step_q      <= '0;
            if (hit) begin
              state_q <= ST_COL;
            end else if (open_q) begin
              ras_n_o   <= 1'b1;
              open_q    <= 1'b0;
              pre_ref_q <= 1'b0;
              state_q   <= ST_PRE;
            end else begin
              dram_addr_o <= PIN_W'(req_addr_i[ADDR_W-1 -: ROW_W]);
              state_q     <= ST_ROW_ACT;
            end
          end
        end
        ST_PRE: begin
          // RAS stays high for the rest of the row cycle
          if (rc_ok) begin
            if (pre_ref_q) begin
              state_q <= ST_REF;
            end else begin
              dram_addr_o <= PIN_W'(lat_row_q);
              state_q     <= ST_ROW_ACT;
            end
          end
        end
        ST_ROW_ACT: begin
          if (drop_ras) begin
            ras_n_o    <= 1'b0;
            open_q     <= 1'b1;
            open_row_q <= lat_row_q;
            step_q     <= '0;
            state_q    <= ST_COL;
          end
        end
        ST_COL: begin
          unique case (step_q)
            2'd0: begin
              dram_addr_o <= PIN_W'(lat_col_q);
              we_n_o      <= !lat_we_q;
              dq_oe_o     <= lat_we_q;
              dq_o        <= lat_wdata_q;
              step_q      <= 2'd1;
            end
            2'd1: begin
              if (drop_cas) begin
                cas_n_o <= 1'b0;
                oe_n_o  <= lat_we_q;
                step_q  <= 2'd2;
              end
            end
            default: begin
              if (data_ok) begin
                cas_n_o     <= 1'b1;
                oe_n_o      <= 1'b1;
                we_n_o      <= 1'b1;
                dq_oe_o     <= 1'b0;
                rsp_valid_o <= !lat_we_q;
                rsp_data_o  <= dq_i;
                step_q      <= '0;
                state_q     <= ST_IDLE;
              end
            end
          endcase
        end
        ST_REF: begin
          unique case (step_q)
            2'd0: if (drop_cas) begin cas_n_o <= 1'b0; step_q <= 2'd1; end
            2'd1: if (drop_ras) begin ras_n_o <= 1'b0; step_q <= 2'd2; end
            default: begin
              if (ras_age >= AW'(T_RAC)) begin
                ras_n_o <= 1'b1;
                cas_n_o <= 1'b1;
                step_q  <= '0;
                state_q <= ST_IDLE;
              end
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Assertions
  p_row_setup_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $stable(dram_addr_o));
  p_col_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> $stable(dram_addr_o));
  p_wr_strobes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && !ras_n_o && !we_n_o) |-> (oe_n_o && dq_oe_o));
  p_bus_turn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> (!dq_oe_o && !$past(dq_oe_o)));
  p_rd_timing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(ras_age) >= AW'(T_RAC) && $past(cas_age) >= AW'(T_CAC)
                     && $past(!cas_n_o) && $past(!oe_n_o)));
  p_ras_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(ras_age) >= AW'(T_RC));
  p_cas_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> $past(cas_age) >= AW'(T_PC));
  p_hit_col_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> (state_q == ST_COL && $stable(ras_n_o)));
  p_cbr_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && state_q == ST_REF) |-> !cas_n_o);
  p_ref_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ref_pend) |=> (state_q == ST_PRE || state_q == ST_REF));
endmodule

// File: tb/test_dram_ctrl.sv
module test_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
  localparam int T_RAC = 6, T_CAC = 2, T_RC = 11, T_PC = 4, T_REF = 150;
  localparam int ADDR_W = ROW_W + COL_W, PIN_W = 4, DEPTH = 1 << ADDR_W;
  localparam int REF_SLACK = 60;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, rsp_data, dq_o, dq_i = '0;
  logic              rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [PIN_W-1:0]  dram_addr;

  dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RAC(T_RAC),
              .T_CAC(T_CAC), .T_RC(T_RC), .T_PC(T_PC), .T_REF(T_REF)) i_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .dram_addr_o(dram_addr),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .oe_n_o(oe_n),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i));

  typedef struct { logic [ADDR_W-1:0] a; bit we; logic [DATA_W-1:0] d; } req_t;
  req_t              req_q[$];
  logic [DATA_W-1:0] rd_q[$];
  logic [DATA_W-1:0] mem [DEPTH];

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Device model and reference, compared every cycle
  int   ras_cyc = 1000, cas_cyc = 1000, since_ref = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_dq_oe = 1'b0;
  logic [PIN_W-1:0] prev_addr = '0;
  logic [ROW_W-1:0] dev_row = '0, last_row = '0;
  logic [COL_W-1:0] dev_col = '0;
  bit   last_valid = 1'b0, act_seen = 1'b0, rose_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      bit ras_fell, cas_fell;
      ras_fell = prev_ras && !ras_n;
      cas_fell = prev_cas && !cas_n;
      since_ref++;
      if (!oe_n)
        check(!dq_oe && !prev_dq_oe, "R4 bus released before OE low", int'(dq_oe | prev_dq_oe), 0);
      if (!prev_ras && ras_n) rose_seen = 1'b1;
      if (ras_fell) begin
        check(ras_cyc + 1 >= T_RC, "R6 RAS spacing", ras_cyc + 1, T_RC);
        if (!cas_n && !prev_cas) begin
          check(since_ref <= T_REF + REF_SLACK, "R10 refresh interval", since_ref, T_REF);
          check(req_q.size() == 0, "R11 refresh between requests", req_q.size(), 0);
          check(oe_n && we_n, "R10 refresh strobes", int'({oe_n, we_n}), 3);
          since_ref  = 0;
          last_valid = 1'b0;
          act_seen   = 1'b0;
          rose_seen  = 1'b0;
        end else begin
          check(prev_addr == dram_addr, "R1 row address setup", prev_addr, dram_addr);
          dev_row  = dram_addr[ROW_W-1:0];
          act_seen = 1'b1;
        end
        ras_cyc = 0;
      end else if (ras_cyc < 1000) ras_cyc++;

      if (cas_fell) begin
        check(cas_cyc + 1 >= T_PC, "R7 CAS spacing", cas_cyc + 1, T_PC);
        if (!ras_n) begin
          if (req_q.size() == 0) begin
            check(1'b0, "R2 column access with no request", 1, 0);
          end else begin
            req_t r;
            logic [ROW_W-1:0] row;
            logic [COL_W-1:0] col;
            r   = req_q.pop_front();
            row = r.a[ADDR_W-1 -: ROW_W];
            col = r.a[COL_W-1:0];
            dev_col = dram_addr[COL_W-1:0];
            check(prev_addr == dram_addr && dram_addr == PIN_W'(col), "R2 column address",
                  dram_addr, col);
            check(dev_row == row, "R1 latched row", dev_row, row);
            if (last_valid && last_row == row)
              check(!act_seen, "R8 hit without activation", act_seen, 0);
            else
              check(act_seen && (!last_valid || rose_seen), "R9 miss closes and reopens",
                    int'({act_seen, rose_seen}), 3);
            last_valid = 1'b1;
            last_row   = row;
            act_seen   = 1'b0;
            rose_seen  = 1'b0;
            if (r.we) begin
              check(!we_n && oe_n && dq_oe && dq_o == r.d, "R3 write cycle", dq_o, r.d);
              mem[{dev_row, dev_col}] = dq_o;
            end else begin
              check(we_n && !oe_n && !dq_oe, "R4 read strobes", int'({we_n, oe_n, dq_oe}), 4);
              rd_q.push_back(mem[r.a]);
            end
          end
        end
        cas_cyc = 0;
      end else if (cas_cyc < 1000) cas_cyc++;

      if (rsp_valid) begin
        if (rd_q.size() == 0) check(1'b0, "R5 unexpected response", 1, 0);
        else begin
          logic [DATA_W-1:0] exp;
          exp = rd_q.pop_front();
          check(rsp_data == exp, "R5 read data", rsp_data, exp);
        end
      end

      // data valid only once both access times have run out at the next edge
      if (!ras_n && !cas_n && !oe_n && ras_cyc + 1 >= T_RAC && cas_cyc + 1 >= T_CAC)
        dq_i = mem[{dev_row, dev_col}];
      else
        dq_i = ~mem[{dev_row, dev_col}];

      prev_ras   = ras_n;
      prev_cas   = cas_n;
      prev_dq_oe = dq_oe;
      prev_addr  = dram_addr;
    end
  end

  task automatic send(input logic [ADDR_W-1:0] a, input bit we, input logic [DATA_W-1:0] d);
    req_t r;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_we    = we;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    r.a = a; r.we = we; r.d = d;
    req_q.push_back(r);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(i * 7 + 3);
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n, "R12 strobes in reset", int'({ras_n, cas_n, we_n, oe_n}), 15);
    check(!dq_oe && !rsp_valid, "R12 bus and response in reset", int'({dq_oe, rsp_valid}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready && ras_n && cas_n, "R12 ready after reset", int'({req_ready, ras_n, cas_n}), 7);

    // same-row writes then reads
    for (int c = 0; c < 4; c++) send(8'h10 | ADDR_W'(c), 1'b1, DATA_W'(8'hA0 + c));
    for (int c = 0; c < 4; c++) send(8'h10 | ADDR_W'(c), 1'b0, '0);
    idle(5);
    // alternating rows
    for (int k = 0; k < 6; k++) begin
      send(ADDR_W'(8'h25 + k * 16), 1'b1, DATA_W'(k * 11 + 1));
      send(ADDR_W'(8'h13), 1'b0, '0);
      send(ADDR_W'(8'h25 + k * 16), 1'b0, '0);
    end
    idle(20);
    // mixed pattern with gaps
    for (int i = 0; i < 200; i++) begin
      send(ADDR_W'(i * 37 + 11), (i % 3) == 0, DATA_W'(i * 13));
      if (i % 17 == 0) idle(i % 5);
    end
    // continuous hit stream across several refresh intervals
    for (int i = 0; i < 120; i++) send(ADDR_W'(8'h50 | (i % 16)), (i % 4) == 1, DATA_W'(i));
    idle(60);
    check(req_q.size() == 0, "R5 all requests served", req_q.size(), 0);
    check(rd_q.size() == 0, "R5 all reads answered", rd_q.size(), 0);
    check(since_ref <= T_REF + REF_SLACK, "R10 refresh still running", since_ref, T_REF);
    finish_run();
  end
endmodule